// File: doc/BRIEF.md
# Keyboard Scan-Code Wake Detector

This block listens to the clock and data wires of a PS/2-style keyboard. It never drives them. It runs on a slow sampling clock of about 32 kHz. It rebuilds every frame the keyboard sends and checks each correctly framed byte against one programmable scan code. When a byte matches, the block sets a sticky status flag. If the wake enable is also set, the flag raises a wake request. The request also appears on a pin whose active level can be programmed.

A small register port gives access to the scan code, a control register and the status flag.

The control register has three bits:
- a wake enable,
- an off switch that holds all frame logic idle,
- a pin polarity select.

Software clears the status flag by writing a one to it. Each byte is compared on its own. A byte that follows a prefix byte still matches if it equals the programmed code.

Top module: `kbw_wake_top`

## Requirements
- R1: A frame is 11 bits, each taken on a falling edge of the keyboard clock, with a high data level read as 1. The order is a start bit, eight data bits least significant first, a parity bit and a stop bit. A valid frame whose byte equals the scan code sets status bit 0 at address 2.
- R2: A frame is accepted only if the data byte together with the parity bit holds an odd number of ones. A frame that fails this check sets no status.
- R3: A frame is accepted only if its start bit is 0 and its stop bit is 1. A frame that fails either check sets no status.
- R4: Control bit 1 at address 1 is the off switch. While it is 1, frames are ignored and never set status. After it returns to 0, detection works again.
- R5: Once the status bit is set, it stays at 1 through later frames, whether they match or not.
- R6: Writing a value with bit 0 = 1 to address 2 clears the status bit. Writing bit 0 = 0 to that address leaves it unchanged.
- R7: The output wakeReq is 1 exactly when the status bit and control bit 0 (the wake enable) at address 1 are both 1.
- R8: Control bit 2 at address 1 sets the pin polarity. When it is 0, wakePin is active low and equals the inverse of wakeReq. When it is 1, wakePin equals wakeReq.
- R9: If the keyboard clock stays high for TIMEOUT_CYCLES sampling cycles while a frame is partly received, the partial frame is discarded. The next full frame is then decoded from its own start bit.
- R10: Address 0 holds the 8-bit scan code and reads back what was written. Every accepted byte is compared on its own, with no tracking of prefix bytes.
- R11: After reset, the scan code is 0x00, the control register is 0, the status is 0 and wakeReq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (about 32 kHz) |
| rstN | input | 1 | Active-low standby reset |
| kbClk | input | 1 | Keyboard clock line, asynchronous |
| kbData | input | 1 | Keyboard data line, asynchronous |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 = code, 1 = control, 2 = status |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for regAddr |
| wakeReq | output | 1 | Internal wake request, active high |
| wakePin | output | 1 | Wake pin with programmable polarity |

## Verification
Two scan codes are each swept against all 256 possible bytes, so a comparator with a dropped or swapped bit, or a shifter with the wrong bit order, marks the wrong byte as a match.

Frames are also sent with the matching byte but with bad parity, a high start bit or a low stop bit. A design that skips any one of these checks would wake on corrupt data.

A truncated frame followed by a long idle gap checks the timeout. Without it, the counter would stay out of step and the next good frame would be missed.

Further tests cover:
- the prefix byte then code pair,
- a write of zero to the status flag,
- both pin polarities,
- a frame sent while the block is switched off.

Each catches a design that tracks state it should not, clears on the wrong write, inverts the pin the wrong way, or keeps sampling when off.

// File: rtl/kbw_pkg.sv
package kbw_pkg;
  typedef struct packed {
    logic shiftEn;
    logic clearFrame;
    logic checkFrame;
  } kbwStrobes_t;

  localparam int OVERHEAD_BITS = 3;
endpackage

// File: rtl/kbw_datapath.sv
module kbw_datapath
  import kbw_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              kbClk,
  input  logic              kbData,
  input  kbwStrobes_t       strobes,
  input  logic [CODE_W-1:0] scanCode,
  output logic              kbClkFall,
  output logic              kbClkLevel,
  output logic              matchHit
);
  localparam int FRAME_W = CODE_W + OVERHEAD_BITS;

  logic [SYNC_STAGES-1:0] clkSync;
  logic [SYNC_STAGES-1:0] dataSync;
  logic                   clkPrev;
  logic [FRAME_W-1:0]     frameSr;

  // both lines idle high; held there while the block is off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync  <= '1;
      dataSync <= '1;
      clkPrev  <= 1'b1;
    end else if (!runEn) begin
      clkSync  <= '1;
      dataSync <= '1;
      clkPrev  <= 1'b1;
    end else begin
      clkSync  <= {clkSync[SYNC_STAGES-2:0], kbClk};
      dataSync <= {dataSync[SYNC_STAGES-2:0], kbData};
      clkPrev  <= clkSync[SYNC_STAGES-1];
    end
  end

  assign kbClkLevel = clkSync[SYNC_STAGES-1];
  assign kbClkFall  = clkPrev & ~clkSync[SYNC_STAGES-1];

  // bits enter at the top and move down, so the first bit ends at index 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameSr <= '0;
    end else if (!runEn || strobes.clearFrame) begin
      frameSr <= '0;
    end else if (strobes.shiftEn) begin
      frameSr <= {dataSync[SYNC_STAGES-1], frameSr[FRAME_W-1:1]};
    end
  end

  logic              startOk;
  logic              stopOk;
  logic              parityOk;
  logic [CODE_W-1:0] rxByte;

  always_comb begin
    startOk  = ~frameSr[0];
    stopOk   = frameSr[FRAME_W-1];
    parityOk = ^frameSr[FRAME_W-2:1];
    rxByte   = frameSr[CODE_W:1];
    matchHit = strobes.checkFrame & startOk & stopOk & parityOk &
               (rxByte == scanCode);
  end
endmodule

// File: rtl/kbw_control.sv
module kbw_control
  import kbw_pkg::*;
#(
  parameter int CODE_W         = 8,
  parameter int ADDR_W         = 2,
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CODE_W-1:0] regWrData,
  output logic [CODE_W-1:0] regRdData,
  input  logic              kbClkFall,
  input  logic              kbClkLevel,
  input  logic              matchHit,
  output kbwStrobes_t       strobes,
  output logic              runEn,
  output logic [CODE_W-1:0] scanCode,
  output logic              wakeReq,
  output logic              wakePin
);
  localparam int FRAME_W = CODE_W + OVERHEAD_BITS;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam int IDLE_W  = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(FRAME_W - 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(TIMEOUT_CYCLES - 1);
  localparam logic [ADDR_W-1:0] ADDR_CODE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(2);

  logic wakeEn, offBit, polHigh, statusBit;
  logic [CNT_W-1:0]  bitCnt;
  logic [IDLE_W-1:0] idleCnt;
  logic checkPend, timeoutHit;

  assign runEn = ~offBit;

  // host register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanCode  <= '0;
      wakeEn    <= 1'b0;
      offBit    <= 1'b0;
      polHigh   <= 1'b0;
      statusBit <= 1'b0;
    end else begin
      if (regWrEn && regAddr == ADDR_CODE) scanCode <= regWrData;
      if (regWrEn && regAddr == ADDR_CTRL) begin
        wakeEn  <= regWrData[0];
        offBit  <= regWrData[1];
        polHigh <= regWrData[2];
      end
      // a match in the same cycle wins over a clear
      if (matchHit) statusBit <= 1'b1;
      else if (regWrEn && regAddr == ADDR_STAT && regWrData[0]) statusBit <= 1'b0;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_CODE: regRdData = scanCode;
      ADDR_CTRL: regRdData = CODE_W'({polHigh, offBit, wakeEn});
      ADDR_STAT: regRdData = CODE_W'(statusBit);
      default:   regRdData = '0;
    endcase
  end

  assign wakeReq = statusBit & wakeEn;
  assign wakePin = polHigh ? wakeReq : ~wakeReq;

  // frame sequencing
  assign timeoutHit = (bitCnt != '0) && kbClkLevel && !kbClkFall &&
                      (idleCnt == IDLE_LAST);

  always_comb begin
    strobes.shiftEn    = kbClkFall;
    strobes.clearFrame = timeoutHit;
    strobes.checkFrame = checkPend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      idleCnt   <= '0;
      checkPend <= 1'b0;
    end else if (!runEn) begin
      bitCnt    <= '0;
      idleCnt   <= '0;
      checkPend <= 1'b0;
    end else begin
      checkPend <= kbClkFall && (bitCnt == LAST_BIT);
      if (kbClkFall) begin
        bitCnt  <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
        idleCnt <= '0;
      end else if (timeoutHit) begin
        bitCnt  <= '0;
        idleCnt <= '0;
      end else if (kbClkLevel && bitCnt != '0) begin
        idleCnt <= idleCnt + 1'b1;
      end else begin
        idleCnt <= '0;
      end
    end
  end
endmodule

// File: rtl/kbw_wake_top.sv
module kbw_wake_top
  import kbw_pkg::*;
#(
  parameter int CODE_W         = 8,
  parameter int ADDR_W         = 2,
  parameter int SYNC_STAGES    = 2,
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              kbClk,
  input  logic              kbData,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CODE_W-1:0] regWrData,
  output logic [CODE_W-1:0] regRdData,
  output logic              wakeReq,
  output logic              wakePin
);
  kbwStrobes_t       strobes;
  logic              runEn, kbClkFall, kbClkLevel, matchHit;
  logic [CODE_W-1:0] scanCode;

  kbw_control #(
    .CODE_W(CODE_W), .ADDR_W(ADDR_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .kbClkFall(kbClkFall),
    .kbClkLevel(kbClkLevel), .matchHit(matchHit), .strobes(strobes),
    .runEn(runEn), .scanCode(scanCode), .wakeReq(wakeReq), .wakePin(wakePin)
  );

  kbw_datapath #(
    .CODE_W(CODE_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .runEn(runEn), .kbClk(kbClk), .kbData(kbData),
    .strobes(strobes), .scanCode(scanCode), .kbClkFall(kbClkFall),
    .kbClkLevel(kbClkLevel), .matchHit(matchHit)
  );
endmodule

// File: rtl/kbw_checker.sv
module kbw_checker #(
  parameter int CODE_W = 8,
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 4,
  parameter int LAST   = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [CODE_W-1:0] regWrData,
  input logic              statusBit,
  input logic              matchHit,
  input logic              runEn,
  input logic              wakeEn,
  input logic              wakeReq,
  input logic [CNT_W-1:0]  bitCnt
);
  logic clrWrite;
  assign clrWrite = regWrEn && (regAddr == ADDR_W'(2)) && regWrData[0];

  a_r1_match_sets_status: assert property (@(posedge clk) disable iff (!rstN)
    matchHit |=> statusBit);

  a_r5_status_sticky: assert property (@(posedge clk) disable iff (!rstN)
    statusBit && !clrWrite |=> statusBit);

  a_r6_write_one_clears: assert property (@(posedge clk) disable iff (!rstN)
    clrWrite && !matchHit |=> !statusBit);

  a_r4_no_match_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !runEn && !$past(runEn) |-> !matchHit);

  a_r7_req_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    !wakeEn |-> !wakeReq);

  a_r9_count_in_range: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(LAST));
endmodule

bind kbw_wake_top kbw_checker #(
  .CODE_W(CODE_W), .ADDR_W(ADDR_W),
  .CNT_W($clog2(CODE_W + 3)), .LAST(CODE_W + 2)
) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .statusBit(u_ctl.statusBit), .matchHit(matchHit),
  .runEn(runEn), .wakeEn(u_ctl.wakeEn), .wakeReq(wakeReq),
  .bitCnt(u_ctl.bitCnt)
);

// File: tb/kbw_wake_top_tb.sv
module kbw_wake_top_tb;
  localparam int HALF = 4;
  localparam int TIMEOUT = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic kbClk = 1'b1;
  logic kbData = 1'b1;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic wakeReq, wakePin;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  kbw_wake_top #(.TIMEOUT_CYCLES(TIMEOUT)) u_dut (
    .clk(clk), .rstN(rstN), .kbClk(kbClk), .kbData(kbData),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .wakeReq(wakeReq), .wakePin(wakePin)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output int v);
    @(negedge clk);
    regAddr = a;
    #1 v = int'(regRdData);
  endtask

  task automatic sendFrame(input logic [7:0] b, input bit badPar,
                           input bit startV, input bit stopV, input int nBits);
    logic [10:0] f;
    f = {stopV, (~^b) ^ badPar, b, startV};
    for (int i = 0; i < nBits; i++) begin
      @(negedge clk); kbData = f[i];
      repeat (HALF) @(negedge clk);
      kbClk = 1'b0;
      repeat (HALF) @(negedge clk);
      kbClk = 1'b1;
    end
    kbData = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic good(input logic [7:0] b);
    sendFrame(b, 1'b0, 1'b0, 1'b1, 11);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    logic [7:0] codes [2];
    codes[0] = 8'h1C; codes[1] = 8'hF0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11 reset state, R8 default polarity active low
    regRead(2'd0, v); check("R11 code", v, 0);
    regRead(2'd1, v); check("R11 ctrl", v, 0);
    regRead(2'd2, v); check("R11 status", v, 0);
    check("R11 wakeReq", int'(wakeReq), 0);
    check("R8 idle pin low-active", int'(wakePin), 1);

    regWrite(2'd1, 8'h01);
    regRead(2'd1, v); check("R7 ctrl readback", v, 1);

    // R1 R10 R7: sweep every byte against two codes
    foreach (codes[c]) begin
      regWrite(2'd0, codes[c]);
      regRead(2'd0, v); check("R10 code readback", v, int'(codes[c]));
      for (int b = 0; b < 256; b++) begin
        good(8'(b));
        regRead(2'd2, v);
        check("R1 sweep status", v, (8'(b) == codes[c]) ? 1 : 0);
        check("R7 sweep wakeReq", int'(wakeReq), (8'(b) == codes[c]) ? 1 : 0);
        if (v != 0) regWrite(2'd2, 8'h01);
      end
    end
    regWrite(2'd0, 8'h1C);

    // R2 parity
    sendFrame(8'h1C, 1'b1, 1'b0, 1'b1, 11);
    regRead(2'd2, v); check("R2 bad parity", v, 0);
    // R3 framing
    sendFrame(8'h1C, 1'b0, 1'b1, 1'b1, 11);
    regRead(2'd2, v); check("R3 bad start", v, 0);
    sendFrame(8'h1C, 1'b0, 1'b0, 1'b0, 11);
    regRead(2'd2, v); check("R3 bad stop", v, 0);

    // R10 prefix byte then code
    good(8'hE0);
    regRead(2'd2, v); check("R10 prefix alone", v, 0);
    good(8'h1C);
    regRead(2'd2, v); check("R10 after prefix", v, 1);

    // R5 sticky, R6 write-zero ignored
    good(8'h55);
    regRead(2'd2, v); check("R5 sticky", v, 1);
    regWrite(2'd2, 8'hFE);
    regRead(2'd2, v); check("R6 write zero", v, 1);

    // R8 polarity with request active
    check("R8 pol0 active", int'(wakePin), 0);
    regWrite(2'd1, 8'h05);
    check("R8 pol1 active", int'(wakePin), 1);
    regWrite(2'd1, 8'h04);
    check("R7 enable off", int'(wakeReq), 0);
    check("R8 pol1 inactive", int'(wakePin), 0);
    regWrite(2'd1, 8'h01);
    check("R7 enable on", int'(wakeReq), 1);

    regWrite(2'd2, 8'h01);
    regRead(2'd2, v); check("R6 write one", v, 0);

    // R4 off switch
    regWrite(2'd1, 8'h03);
    good(8'h1C);
    regRead(2'd2, v); check("R4 off ignores", v, 0);
    check("R4 off wakeReq", int'(wakeReq), 0);
    regWrite(2'd1, 8'h01);
    good(8'h1C);
    regRead(2'd2, v); check("R4 back on", v, 1);
    regWrite(2'd2, 8'h01);

    // R9 timeout discards partial frame
    sendFrame(8'h1C, 1'b0, 1'b0, 1'b1, 5);
    repeat (TIMEOUT + 20) @(negedge clk);
    good(8'h1C);
    regRead(2'd2, v); check("R9 after timeout", v, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule